// File: doc/BRIEF.md
# Storage Port Bring-Up Sequencer

The block brings one serial storage port from an unknown state to a usable one. It works entirely through a register-access master that has one access in flight at a time. After a start pulse it reads the port's command register. If any activity bit is set it stops command processing, waits a fixed number of milliseconds, and polls until the command engine reports that it has stopped. It then asks the device to spin up with a read-modify-write, and polls the link detection field at millisecond-spaced intervals.

Once a device is seen, or the polls run out, the block clears the port's latched errors by writing back what it read. It acknowledges the controller's pending interrupts, raises this port's bit in the global interrupt status, and writes the interrupt-enable mask. It finishes with one more status read, which decides whether the link is reported as up.

The PHY, out-of-band signalling and the register file are outside the block. Waits are counted in pulses of a millisecond tick input, so the block needs no knowledge of the clock frequency. A timeout while waiting for the command engine to stop ends in a failure state, which holds until the next start.

Top module: `port_bringup_seq`

## Requirements
- R1: While rst_ni is low, done_o, error_o, link_up_o and req_valid_o are all 0.
- R2: A start first reads the command register. If any of bits 0 (start), 4 (receive enable), 14 (receive running) or 15 (engine running) is set, the block writes the read value back with bit 0 cleared. Otherwise it goes straight to spin-up.
- R3: After that write the block lets IDLE_WAIT_MS tick pulses pass, then reads the command register until bit 15 reads 0. If POLL_LIMIT reads in a row show bit 15 set, it enters failure: error_o goes high one cycle after the last read and stays high.
- R4: Spin-up reads the command register and writes back the value it read with bit 1 set.
- R5: Each detection read of the status register comes exactly DET_GAP_MS tick pulses after the previous access. Polling stops when the low 4 bits equal 3 or 1. After DET_TRIES reads without such a value, the sequence goes on without error.
- R6: The block reads the port error register and writes back the same value.
- R7: The block reads global interrupt status. It writes the value back only if it is nonzero, then writes a word with only bit PORT_IDX set.
- R8: The block writes IE_MASK to the interrupt-enable register, then reads the status register once more. One cycle after that read is accepted, done_o rises and link_up_o equals 1 exactly when the low 4 bits of that read were 3. No request is made while done_o or error_o is high.
- R9: Global interrupt status is at BASE_ADDR+0x08. Port registers are at BASE_ADDR+0x100+PORT_IDX*0x80, plus 0x14 for interrupt enable, 0x18 for command, 0x28 for status and 0x30 for error.
- R10: A start pulse while done or failed starts a new sequence. One cycle later done_o, error_o and link_up_o are 0 and the first command read is requested.
- R11: A start pulse while a sequence is in progress has no effect on the access sequence or on the outputs.
- R12: A request holds its address, direction and write data until req_ready_i is seen high. An access completes in the cycle where req_valid_o and req_ready_i are both high, and read data is taken from req_rdata_i in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a bring-up sequence |
| ms_tick_i | input | 1 | One-cycle pulse per millisecond |
| req_valid_o | output | 1 | Register access requested |
| req_write_o | output | 1 | 1 for write, 0 for read |
| req_addr_o | output | ADDR_W | Byte address of the access |
| req_wdata_o | output | DATA_W | Write data |
| req_ready_i | input | 1 | Access accepted this cycle |
| req_rdata_i | input | DATA_W | Read data, valid with req_ready_i on reads |
| done_o | output | 1 | Sequence finished normally |
| link_up_o | output | 1 | Device present with PHY ready |
| error_o | output | 1 | Command engine failed to stop |

## Verification
A corrupted state register shows at the very next accepted access as a wrong address, direction or write data. It can also show as a request where none belongs. In both cases it appears one cycle after the state goes wrong. A miscounted wait shows as a detection or poll read that comes early or late by whole tick periods. A miscounted poll limit shows as error_o rising one read early or late. The bench also compares the final link classification and the done and error flags every cycle. A wrong held read value is therefore caught at the write-back it feeds.

// File: rtl/pb_pkg.sv
package pb_pkg;

  typedef enum logic [4:0] {
    S_IDLE,
    S_CMD_RD,
    S_STOP_WR,
    S_STOP_WAIT,
    S_CR_RD,
    S_SUD_RD,
    S_SUD_WR,
    S_DET_WAIT,
    S_DET_RD,
    S_SERR_RD,
    S_SERR_WR,
    S_GIS_RD,
    S_GIS_WR,
    S_GIS_PORT,
    S_IE_WR,
    S_FIN_RD,
    S_DONE,
    S_FAIL
  } pb_state_e;

  // register layout seen by the controller
  localparam int PORT_BLK_OFS = 'h100;
  localparam int PORT_STRIDE  = 'h80;
  localparam int OFS_GIS      = 'h08;
  localparam int OFS_IE       = 'h14;
  localparam int OFS_CMD      = 'h18;
  localparam int OFS_SSTS     = 'h28;
  localparam int OFS_SERR     = 'h30;

  // command register bits
  localparam int CMD_ST  = 0;
  localparam int CMD_SUD = 1;
  localparam int CMD_FRE = 4;
  localparam int CMD_FR  = 14;
  localparam int CMD_CR  = 15;

  localparam logic [3:0] DET_PHY   = 4'h3;
  localparam logic [3:0] DET_NOPHY = 4'h1;

endpackage

// File: rtl/pb_tick_wait.sv
module pb_tick_wait #(
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             hit_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!en_i)  cnt_q <= '0;
    else if (tick_i) cnt_q <= cnt_q + 1'b1;
  end

  // fires on the tick that completes the interval
  assign hit_o = en_i && tick_i && (cnt_q == limit_i - 1'b1);

endmodule

// File: rtl/pb_try_counter.sv
module pb_try_counter #(
  parameter int LIMIT = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  output logic last_o
);

  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (inc_i)  cnt_q <= cnt_q + 1'b1;
  end

  // true while the LIMIT-th attempt is under way
  assign last_o = (cnt_q == CW'(LIMIT - 1));

endmodule

// File: rtl/pb_access_map.sv
module pb_access_map
  import pb_pkg::*;
#(
  parameter int                ADDR_W    = 32,
  parameter int                DATA_W    = 32,
  parameter logic [ADDR_W-1:0] BASE_ADDR = '0,
  parameter int                PORT_IDX  = 0,
  parameter logic [DATA_W-1:0] IE_MASK   = '1
) (
  input  pb_state_e         state_i,
  input  logic [DATA_W-1:0] held_i,
  output logic              valid_o,
  output logic              write_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o
);

  localparam logic [ADDR_W-1:0] PORT_BASE =
    BASE_ADDR + ADDR_W'(PORT_BLK_OFS + PORT_IDX * PORT_STRIDE);
  localparam logic [ADDR_W-1:0] A_CMD  = PORT_BASE + ADDR_W'(OFS_CMD);
  localparam logic [ADDR_W-1:0] A_SSTS = PORT_BASE + ADDR_W'(OFS_SSTS);
  localparam logic [ADDR_W-1:0] A_SERR = PORT_BASE + ADDR_W'(OFS_SERR);
  localparam logic [ADDR_W-1:0] A_IE   = PORT_BASE + ADDR_W'(OFS_IE);
  localparam logic [ADDR_W-1:0] A_GIS  = BASE_ADDR + ADDR_W'(OFS_GIS);
  localparam logic [DATA_W-1:0] ST_BIT   = DATA_W'(1) << CMD_ST;
  localparam logic [DATA_W-1:0] SUD_BIT  = DATA_W'(1) << CMD_SUD;
  localparam logic [DATA_W-1:0] PORT_BIT = DATA_W'(1) << PORT_IDX;

  always_comb begin
    valid_o = 1'b1;
    write_o = 1'b0;
    addr_o  = A_CMD;
    wdata_o = '0;
    unique case (state_i)
      S_CMD_RD, S_CR_RD, S_SUD_RD: addr_o = A_CMD;
      S_STOP_WR: begin write_o = 1'b1; wdata_o = held_i & ~ST_BIT; end
      S_SUD_WR:  begin write_o = 1'b1; wdata_o = held_i | SUD_BIT;  end
      S_DET_RD, S_FIN_RD: addr_o = A_SSTS;
      S_SERR_RD: addr_o = A_SERR;
      S_SERR_WR: begin addr_o = A_SERR; write_o = 1'b1; wdata_o = held_i; end
      S_GIS_RD:  addr_o = A_GIS;
      S_GIS_WR:  begin addr_o = A_GIS; write_o = 1'b1; wdata_o = held_i; end
      S_GIS_PORT: begin addr_o = A_GIS; write_o = 1'b1; wdata_o = PORT_BIT; end
      S_IE_WR:   begin addr_o = A_IE; write_o = 1'b1; wdata_o = IE_MASK; end
      default:   valid_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/port_bringup_seq.sv
module port_bringup_seq
  import pb_pkg::*;
#(
  parameter int                ADDR_W       = 32,
  parameter int                DATA_W       = 32,
  parameter logic [ADDR_W-1:0] BASE_ADDR    = '0,
  parameter int                PORT_IDX     = 0,
  parameter int                POLL_LIMIT   = 1000,
  parameter int                IDLE_WAIT_MS = 500,
  parameter int                DET_GAP_MS   = 10,
  parameter int                DET_TRIES    = 100,
  parameter logic [DATA_W-1:0] IE_MASK      = DATA_W'(32'h7800_004F)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              ms_tick_i,
  output logic              req_valid_o,
  output logic              req_write_o,
  output logic [ADDR_W-1:0] req_addr_o,
  output logic [DATA_W-1:0] req_wdata_o,
  input  logic              req_ready_i,
  input  logic [DATA_W-1:0] req_rdata_i,
  output logic              done_o,
  output logic              link_up_o,
  output logic              error_o
);

  localparam int MAX_WAIT = (IDLE_WAIT_MS > DET_GAP_MS) ? IDLE_WAIT_MS : DET_GAP_MS;
  localparam int WAIT_W   = $clog2(MAX_WAIT + 1);
  localparam logic [DATA_W-1:0] BUSY_MASK =
    (DATA_W'(1) << CMD_ST) | (DATA_W'(1) << CMD_FRE) |
    (DATA_W'(1) << CMD_FR) | (DATA_W'(1) << CMD_CR);

  pb_state_e         state_q, state_d;
  logic [DATA_W-1:0] held_q;
  logic              link_q;
  logic              xfer, start_ok, wait_en, wait_hit, cr_last, det_last;
  logic              det_found;
  logic [3:0]        det;
  logic [WAIT_W-1:0] wait_lim;

  assign xfer      = req_valid_o && req_ready_i;
  assign start_ok  = start_i && (state_q == S_IDLE || state_q == S_DONE || state_q == S_FAIL);
  assign det       = req_rdata_i[3:0];
  assign det_found = (det == DET_PHY) || (det == DET_NOPHY);
  assign wait_en   = (state_q == S_STOP_WAIT) || (state_q == S_DET_WAIT);
  assign wait_lim  = (state_q == S_STOP_WAIT) ? WAIT_W'(IDLE_WAIT_MS) : WAIT_W'(DET_GAP_MS);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE, S_DONE, S_FAIL: if (start_ok) state_d = S_CMD_RD;
      S_CMD_RD:
        if (xfer) state_d = |(req_rdata_i & BUSY_MASK) ? S_STOP_WR : S_SUD_RD;
      S_STOP_WR:   if (xfer) state_d = S_STOP_WAIT;
      S_STOP_WAIT: if (wait_hit) state_d = S_CR_RD;
      S_CR_RD:
        if (xfer) begin
          if (!req_rdata_i[CMD_CR]) state_d = S_SUD_RD;
          else if (cr_last)         state_d = S_FAIL;
        end
      S_SUD_RD:    if (xfer) state_d = S_SUD_WR;
      S_SUD_WR:    if (xfer) state_d = S_DET_WAIT;
      S_DET_WAIT:  if (wait_hit) state_d = S_DET_RD;
      S_DET_RD:
        if (xfer) state_d = (det_found || det_last) ? S_SERR_RD : S_DET_WAIT;
      S_SERR_RD:   if (xfer) state_d = S_SERR_WR;
      S_SERR_WR:   if (xfer) state_d = S_GIS_RD;
      S_GIS_RD:
        if (xfer) state_d = (req_rdata_i != '0) ? S_GIS_WR : S_GIS_PORT;
      S_GIS_WR:    if (xfer) state_d = S_GIS_PORT;
      S_GIS_PORT:  if (xfer) state_d = S_IE_WR;
      S_IE_WR:     if (xfer) state_d = S_FIN_RD;
      S_FIN_RD:    if (xfer) state_d = S_DONE;
      default:     state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      held_q  <= '0;
      link_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (xfer && !req_write_o) held_q <= req_rdata_i;
      if (start_ok)                          link_q <= 1'b0;
      else if (xfer && state_q == S_FIN_RD)  link_q <= (det == DET_PHY);
    end
  end

  pb_tick_wait #(.CNT_W(WAIT_W)) u_wait (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (wait_en),
    .tick_i  (ms_tick_i),
    .limit_i (wait_lim),
    .hit_o   (wait_hit)
  );

  pb_try_counter #(.LIMIT(POLL_LIMIT)) u_cr_tries (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (state_q == S_STOP_WAIT),
    .inc_i  (xfer && state_q == S_CR_RD),
    .last_o (cr_last)
  );

  pb_try_counter #(.LIMIT(DET_TRIES)) u_det_tries (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (state_q == S_SUD_WR),
    .inc_i  (xfer && state_q == S_DET_RD),
    .last_o (det_last)
  );

  pb_access_map #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .BASE_ADDR (BASE_ADDR),
    .PORT_IDX  (PORT_IDX),
    .IE_MASK   (IE_MASK)
  ) u_map (
    .state_i (state_q),
    .held_i  (held_q),
    .valid_o (req_valid_o),
    .write_o (req_write_o),
    .addr_o  (req_addr_o),
    .wdata_o (req_wdata_o)
  );

  assign done_o    = (state_q == S_DONE);
  assign error_o   = (state_q == S_FAIL);
  assign link_up_o = link_q;

endmodule

// File: rtl/pb_bringup_chk.sv
module pb_bringup_chk
  import pb_pkg::*;
#(
  parameter int                ADDR_W    = 32,
  parameter int                DATA_W    = 32,
  parameter logic [ADDR_W-1:0] BASE_ADDR = '0,
  parameter int                PORT_IDX  = 0
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              req_valid_o,
  input logic              req_write_o,
  input logic [ADDR_W-1:0] req_addr_o,
  input logic [DATA_W-1:0] req_wdata_o,
  input logic              req_ready_i,
  input logic              done_o,
  input logic              link_up_o,
  input logic              error_o
);

  localparam logic [ADDR_W-1:0] PB = BASE_ADDR + ADDR_W'('h100) + ADDR_W'(PORT_IDX * 'h80);

  p_req_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o && !req_ready_i |=> req_valid_o && $stable(req_addr_o) &&
      $stable(req_write_o) && $stable(req_wdata_o));

  p_end_excl_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && error_o));

  p_link_done_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    link_up_o |-> done_o);

  p_quiet_end_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o || error_o) |-> !req_valid_o);

  p_restart_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && (done_o || error_o) |=> !done_o && !error_o && req_valid_o);

  p_fail_sticky_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    error_o && !start_i |=> error_o);

  p_addr_map_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o |-> (req_addr_o == PB + ADDR_W'('h18)) || (req_addr_o == PB + ADDR_W'('h28)) ||
      (req_addr_o == PB + ADDR_W'('h30)) || (req_addr_o == PB + ADDR_W'('h14)) ||
      (req_addr_o == BASE_ADDR + ADDR_W'('h08)));

endmodule

bind port_bringup_seq pb_bringup_chk #(
  .ADDR_W    (ADDR_W),
  .DATA_W    (DATA_W),
  .BASE_ADDR (BASE_ADDR),
  .PORT_IDX  (PORT_IDX)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .req_valid_o (req_valid_o),
  .req_write_o (req_write_o),
  .req_addr_o  (req_addr_o),
  .req_wdata_o (req_wdata_o),
  .req_ready_i (req_ready_i),
  .done_o      (done_o),
  .link_up_o   (link_up_o),
  .error_o     (error_o)
);

// File: tb/port_bringup_seq_test.sv
module port_bringup_seq_test;

  localparam int          PIDX  = 2;
  localparam int          POLL  = 4;
  localparam int          IWAIT = 3;
  localparam int          GAP   = 2;
  localparam int          TRIES = 5;
  localparam logic [31:0] BASE  = 32'h0000_4000;
  localparam logic [31:0] IEM   = 32'h7800_004F;
  localparam logic [31:0] PB    = BASE + 32'h100 + PIDX * 32'h80;
  localparam logic [31:0] A_CMD = PB + 32'h18;
  localparam logic [31:0] A_SST = PB + 32'h28;
  localparam logic [31:0] A_SER = PB + 32'h30;
  localparam logic [31:0] A_IE  = PB + 32'h14;
  localparam logic [31:0] A_GIS = BASE + 32'h08;
  localparam logic [31:0] CRB   = 32'h0000_8000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic tick = 1'b0;
  logic ready = 1'b0;
  logic [31:0] rdata = '0;
  logic        vld, wr, done, link, err;
  logic [31:0] addr, wdata;

  always #5 clk = ~clk;

  port_bringup_seq #(
    .BASE_ADDR(BASE), .PORT_IDX(PIDX), .POLL_LIMIT(POLL), .IDLE_WAIT_MS(IWAIT),
    .DET_GAP_MS(GAP), .DET_TRIES(TRIES), .IE_MASK(IEM)
  ) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .ms_tick_i(tick),
    .req_valid_o(vld), .req_write_o(wr), .req_addr_o(addr), .req_wdata_o(wdata),
    .req_ready_i(ready), .req_rdata_i(rdata),
    .done_o(done), .link_up_o(link), .error_o(err)
  );

  // scenario inputs, written by the main process only
  logic [31:0] s_cmd, s_serr, s_gis;
  int          s_hold;
  logic [31:0] s_det [0:7];
  int          start_req = 0, busy_req = 0;

  // model state, owned by the clocked process
  int          n_chk = 0, n_err = 0, cyc = 0;
  int          start_ack = 0, busy_ack = 0;
  logic        running = 0, exp_done = 0, exp_err = 0, exp_link = 0;
  logic        end_err, end_link, fin = 0, busy_seen = 0;
  int          err_snap, tick_cnt;
  logic [31:0] q_addr[$], q_dat[$];
  logic        q_wr[$];
  int          q_min[$];
  string       q_tag[$];
  logic [31:0] cmd_reg;
  logic        stopped;
  int          cr_left, det_idx;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic push(input logic [31:0] a, input logic w, input logic [31:0] d,
                      input int mn, input string t);
    q_addr.push_back(a); q_wr.push_back(w); q_dat.push_back(d);
    q_min.push_back(mn); q_tag.push_back(t);
  endtask

  // expected access list from the requirements
  task automatic build();
    logic [31:0] cur, v;
    int idx;
    q_addr.delete(); q_wr.delete(); q_dat.delete(); q_min.delete(); q_tag.delete();
    cmd_reg = s_cmd; stopped = 0; cr_left = s_hold; det_idx = 0;
    push(A_CMD, 0, 0, 0, "R2");
    cur = s_cmd;
    if ((s_cmd & 32'h0000_C011) != 0) begin
      cur = s_cmd & ~32'h1;
      push(A_CMD, 1, cur, 0, "R2");
      for (int p = 0; ; p++) begin
        push(A_CMD, 0, 0, (p == 0) ? IWAIT : 0, "R3");
        if (!((cur & CRB) != 0 && p < s_hold)) begin cur = cur & ~CRB; break; end
        if (p == POLL - 1) begin
          end_err = 1; end_link = 0;
          return;
        end
      end
    end
    push(A_CMD, 0, 0, 0, "R4");
    push(A_CMD, 1, cur | 32'h2, 0, "R4");
    idx = 0;
    for (int t = 0; t < TRIES; t++) begin
      v = s_det[idx]; idx++;
      push(A_SST, 0, 0, GAP, "R5");
      if (v[3:0] == 4'h1 || v[3:0] == 4'h3) break;
    end
    push(A_SER, 0, 0, 0, "R6");
    push(A_SER, 1, s_serr, 0, "R6");
    push(A_GIS, 0, 0, 0, "R7");
    if (s_gis != 0) push(A_GIS, 1, s_gis, 0, "R7");
    push(A_GIS, 1, 32'h1 << PIDX, 0, "R7");
    push(A_IE, 1, IEM, 0, "R8");
    push(A_SST, 0, 0, 0, "R8");
    end_link = (s_det[idx][3:0] == 4'h3);
    end_err  = 0;
  endtask

  function automatic logic [31:0] rd_model(input logic [31:0] a);
    logic [31:0] r;
    r = 32'hDEAD_BEEF;
    if (a == A_CMD) begin
      if (stopped && (cmd_reg & CRB) != 0) begin
        if (cr_left > 0) cr_left--;
        else cmd_reg = cmd_reg & ~CRB;
      end
      r = cmd_reg;
    end else if (a == A_SST) begin
      r = s_det[det_idx]; det_idx++;
    end else if (a == A_SER) r = s_serr;
    else if (a == A_GIS) r = s_gis;
    return r;
  endfunction

  always @(negedge clk) begin
    if (!rst_n) begin
      chk(!done && !err && !link && !vld, "R1 reset state", {28'b0, done, err, link, vld}, 0);
    end else if (!fin) begin
      cyc++;
      if (cyc > 100000) begin
        chk(0, "watchdog expired", cyc, 0);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
      end
      chk(done == exp_done, "R8 done_o", done, exp_done);
      chk(err == exp_err, "R3 R10 error_o", err, exp_err);
      chk(link == exp_link, "R8 link_up_o", link, exp_link);
      if (vld && (!running || q_addr.size() == 0))
        chk(0, "R8 request outside sequence", addr, 0);
      start = 0;
      if (start_req != start_ack && !running) begin
        start = 1; start_ack++; running = 1;
        exp_done = 0; exp_err = 0; exp_link = 0; tick_cnt = 0;
        build();
      end else if (busy_req != busy_ack) begin
        start = 1; busy_ack++; busy_seen = 1; err_snap = n_err;
      end
      ready = (cyc % 3) != 1;
      tick  = (cyc % 5) == 0;
      rdata = '0;
      if (vld && ready && running && q_addr.size() > 0) begin
        logic [31:0] ea, ed; logic ew; int mn; string tg;
        ea = q_addr.pop_front(); ew = q_wr.pop_front(); ed = q_dat.pop_front();
        mn = q_min.pop_front(); tg = q_tag.pop_front();
        chk(addr == ea, {tg, " R9 address"}, addr, ea);
        chk(wr == ew, {tg, " R12 direction"}, wr, ew);
        if (ew) chk(wdata == ed, {tg, " write data"}, wdata, ed);
        chk(tick_cnt == mn, {tg, " tick spacing"}, tick_cnt, mn);
        tick_cnt = 0;
        if (!wr) rdata = rd_model(addr);
        else if (addr == A_CMD) begin cmd_reg = wdata; stopped = 1; end
        if (q_addr.size() == 0) begin
          running = 0;
          exp_done = !end_err; exp_err = end_err; exp_link = end_link;
          if (busy_seen) begin
            chk(n_err == err_snap, "R11 start while busy changed sequence", n_err, err_snap);
            busy_seen = 0;
          end
        end
      end else if (tick && !vld) tick_cnt++;
    end
  end

  task automatic run(input logic [31:0] c, input int hold, input logic [31:0] sv,
                     input logic [31:0] gv, input bit poke);
    s_cmd = c; s_hold = hold; s_serr = sv; s_gis = gv;
    @(posedge clk); #1 start_req++;
    wait (start_ack == start_req);
    if (poke) begin repeat (12) @(posedge clk); #1 busy_req++; end
    wait (!running);
    repeat (6) @(posedge clk);
  endtask

  task automatic set_det(input logic [31:0] a, b, c, d, e, f);
    s_det[0] = a; s_det[1] = b; s_det[2] = c; s_det[3] = d; s_det[4] = e; s_det[5] = f;
    s_det[6] = 0; s_det[7] = 0;
  endtask

  initial begin
    s_cmd = 0; s_serr = 0; s_gis = 0; s_hold = 0;
    set_det(0, 0, 0, 0, 0, 0);
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    repeat (4) @(posedge clk);
    // R2 idle path, R5 found on third poll, R7 zero status, final PHY up
    set_det(32'h0, 32'h0, 32'h3, 32'h103, 0, 0);
    run(32'h0, 0, 32'h0400_0001, 32'h0, 0);
    // R2/R3 busy path with two busy polls, R5 no-PHY, R7 nonzero, R11 poke
    set_det(32'h2, 32'h1, 32'h1, 0, 0, 0);
    run(32'h0000_C011, 2, 32'h0000_0800, 32'h5, 1);
    // R3 engine never stops: failure
    set_det(0, 0, 0, 0, 0, 0);
    run(32'h0000_8001, 10, 32'h0, 32'h0, 0);
    // R10 restart from failure, R5 polls exhausted, upper status bits ignored
    set_det(32'h104, 32'h104, 32'h104, 32'h104, 32'h104, 32'h123);
    run(32'h0000_0010, 0, 32'hFFFF_FFFF, 32'h8000_0000, 0);
    // R4 spin-up bit already set, R8 device gone on last read
    set_det(32'h3, 32'h0, 0, 0, 0, 0);
    run(32'h0000_0002, 0, 32'h0, 32'h1 << PIDX, 0);
    fin = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule